// File: doc/BRIEF.md
# Ripple-Carry Bit-Slice Arithmetic-Logic Unit

This block is a purely combinational integer arithmetic-logic unit. It is built from one identical single-bit cell per operand bit, chained by a rippling carry. A four-bit control word selects among bitwise AND, OR and NOR, addition, subtraction and signed set-less-than. The block reports the result, a flag that is high when every result bit is zero, the carry out of the top cell, and a signed overflow flag.

Subtraction and comparison reuse the same adder. One control bit complements B and also forces the carry into bit 0 high, so the adder forms A + ~B + 1. For a comparison, the top cell produces a "less" bit from the sign of that difference, corrected by the overflow flag. This bit loops back into the lowest cell, and every other cell's less input is held at zero. NOR is obtained by complementing both operands and taking the AND path. Unsigned callers simply ignore the overflow flag.

Top module: `rc_alu`

## Requirements
- R1: Control 4'b0000 yields A AND B, and control 4'b0001 yields A OR B.
- R2: Control 4'b0010 yields (A + B) mod 2^WIDTH, and the carry output is the unsigned carry out of that sum.
- R3: Control 4'b0110 yields (A - B) mod 2^WIDTH, and the carry output is 1 exactly when A >= B taken as unsigned values.
- R4: The overflow output is high exactly when the two operands entering the adder share a sign bit and the sum's sign bit differs from it. For 4'b0010 and 4'b0110 this is signed two's-complement overflow.
- R5: Control 4'b0111 yields 1 when A < B as signed values and 0 otherwise, and the result is correct even when A - B overflows. All result bits above bit 0 are 0.
- R6: Control 4'b1100 yields NOT (A OR B).
- R7: The zero output is high exactly when every result bit is 0.
- R8: For every control code, bit 3 complements A before the cell, and bit 2 complements B and sets the carry into bit 0. Bits [1:0] pick the cell output: 00 AND, 01 OR, 10 sum, 11 less. The carry and overflow outputs always come from the adder, whatever the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| ctrl_i | input | 4 | {invert A, invert B and carry-in, select[1:0]} |
| result_o | output | WIDTH | Selected result |
| zero_o | output | 1 | High when the result is all zeros |
| carry_o | output | 1 | Carry out of the most significant cell |
| ovf_o | output | 1 | Signed overflow of the adder |

## Verification
The bench works hardest on signed comparisons whose difference overflows, such as the most negative value against a positive one. A design that used the raw sign bit would return the inverted answer there. Equal and all-ones operands for subtraction test the carry-as-not-borrow rule; a missing carry-in would make the result off by one and the carry wrong. Overflow is checked at both sign extremes, because reading the wrong carry pair misses one direction. NOR and the flag outputs of the logic codes are checked as well, since a selector that confused the inverters, or flags gated by the operation, would differ only there.

// File: rtl/rc_alu_pkg.sv
package rc_alu_pkg;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } sel_e;

  typedef struct packed {
    logic a_inv;
    logic b_inv;
    sel_e sel;
  } ctrl_t;

  localparam logic [3:0] CTRL_AND = 4'b0000;
  localparam logic [3:0] CTRL_OR  = 4'b0001;
  localparam logic [3:0] CTRL_ADD = 4'b0010;
  localparam logic [3:0] CTRL_SUB = 4'b0110;
  localparam logic [3:0] CTRL_SLT = 4'b0111;
  localparam logic [3:0] CTRL_NOR = 4'b1100;

  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

endpackage

// File: rtl/rc_alu_slice.sv
module rc_alu_slice
  import rc_alu_pkg::*;
#(
  parameter bit IS_TOP = 1'b0
) (
  input  logic a,
  input  logic b,
  input  logic a_inv,
  input  logic b_inv,
  input  sel_e sel,
  input  logic cin,
  input  logic less,
  output logic res,
  output logic cout,
  output logic set_o,
  output logic ovf_o
);

  logic ax, bx, sum;

  always_comb begin
    ax   = a_inv ? ~a : a;
    bx   = b_inv ? ~b : b;
    sum  = fa_sum(ax, bx, cin);
    cout = fa_carry(ax, bx, cin);
    unique case (sel)
      SEL_AND:  res = ax & bx;
      SEL_OR:   res = ax | bx;
      SEL_SUM:  res = sum;
      default:  res = less;
    endcase
  end

  generate
    if (IS_TOP) begin : g_top
      always_comb begin
        ovf_o = cin ^ cout;
        set_o = sum ^ ovf_o;
        if (ovf_o)
          assert_ovf_sign_R4: assert ((ax == bx) && (sum != ax));
        else
          assert_no_ovf_sign_R4: assert ((ax != bx) || (sum == ax));
      end
    end else begin : g_low
      assign ovf_o = 1'b0;
      assign set_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/rc_alu_zero.sv
module rc_alu_zero #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] v,
  output logic             zero
);
  assign zero = ~(|v);
endmodule

// File: rtl/rc_alu.sv
module rc_alu
  import rc_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       ctrl_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             carry_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  ctrl_t ctrl;
  logic  msb_set;
  logic  msb_cout;
  logic  msb_ovf;

  assign ctrl = ctrl_t'(ctrl_i);

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic co;
      logic ci;
      logic lin;
      logic st;
      logic ov;
      if (i == 0) begin : g_first
        assign ci  = ctrl.b_inv;
        assign lin = msb_set;
      end else begin : g_rest
        assign ci  = g_bit[i-1].co;
        assign lin = 1'b0;
      end
      rc_alu_slice #(.IS_TOP(i == MSB)) u_slice (
        .a     (a_i[i]),
        .b     (b_i[i]),
        .a_inv (ctrl.a_inv),
        .b_inv (ctrl.b_inv),
        .sel   (ctrl.sel),
        .cin   (ci),
        .less  (lin),
        .res   (result_o[i]),
        .cout  (co),
        .set_o (st),
        .ovf_o (ov)
      );
    end
  endgenerate

  assign msb_set  = g_bit[MSB].st;
  assign msb_cout = g_bit[MSB].co;
  assign msb_ovf  = g_bit[MSB].ov;
  assign carry_o  = msb_cout;
  assign ovf_o    = msb_ovf;

  rc_alu_zero #(.WIDTH(WIDTH)) u_zero (
    .v    (result_o),
    .zero (zero_o)
  );

  always_comb begin
    if (ctrl_i == CTRL_ADD)
      assert_add_R2: assert ({carry_o, result_o} == ({1'b0, a_i} + {1'b0, b_i}));
    if (ctrl_i == CTRL_SUB)
      assert_sub_R3: assert ((result_o == a_i - b_i) && (carry_o == (a_i >= b_i)));
    if (ctrl.sel == SEL_LESS)
      assert_less_upper_R5: assert (result_o[MSB:1] == '0);
    if (ctrl_i == CTRL_SLT)
      assert_slt_R5: assert (result_o[0] == ($signed(a_i) < $signed(b_i)));
    assert_zero_flag_R7: assert (zero_o != (|result_o));
  end

endmodule

// File: tb/sim_rc_alu.sv
module sim_rc_alu;

  localparam int SW = 4;
  localparam int BW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2ns clk = ~clk;

  logic [SW-1:0] sa, sb;
  logic [3:0]    sc;
  logic [SW-1:0] sres;
  logic          sz, scy, sov;

  logic [BW-1:0] ba, bb;
  logic [3:0]    bc;
  logic [BW-1:0] bres;
  logic          bz, bcy, bov;

  rc_alu #(.WIDTH(SW)) u0 (
    .a_i(sa), .b_i(sb), .ctrl_i(sc),
    .result_o(sres), .zero_o(sz), .carry_o(scy), .ovf_o(sov)
  );

  rc_alu #(.WIDTH(BW)) u1 (
    .a_i(ba), .b_i(bb), .ctrl_i(bc),
    .result_o(bres), .zero_o(bz), .carry_o(bcy), .ovf_o(bov)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic longint sx(input longint v, input int w);
    return v[w-1] ? v - (longint'(1) << w) : v;
  endfunction

  // Reference model: {result, zero, carry, ovf}
  function automatic longint model(input longint a, input longint b, input int c, input int w,
                                   output bit z, output bit cy, output bit ov);
    longint m = (longint'(1) << w) - 1;
    longint ea = c[3] ? (~a & m) : a;
    longint eb = c[2] ? (~b & m) : b;
    longint full = ea + eb + (c[2] ? 1 : 0);
    longint s = full & m;
    longint r;
    bit lt;
    cy = full[w];
    ov = (ea[w-1] == eb[w-1]) && (s[w-1] != ea[w-1]);
    lt = s[w-1] ^ ov;
    case (c[1:0])
      2'd0: r = ea & eb;
      2'd1: r = ea | eb;
      2'd2: r = s;
      default: r = lt;
    endcase
    z = (r == 0);
    return r;
  endfunction

  task automatic check_small(input int a, input int b, input int c);
    bit z, cy, ov;
    longint r;
    longint m = 15;
    r = model(a, b, c, SW, z, cy, ov);
    chk("R8 result", sres, r);
    chk("R8 carry", scy, cy);
    chk("R4 ovf", sov, ov);
    chk("R7 zero", sz, (sres == 0));
    case (c)
      0:  chk("R1 and", sres, a & b);
      1:  chk("R1 or", sres, a | b);
      2: begin
        chk("R2 add", sres, (a + b) & m);
        chk("R2 carry", scy, (a + b) > m);
        chk("R4 add ovf", sov, (sx(a, SW) + sx(b, SW) > 7) || (sx(a, SW) + sx(b, SW) < -8));
      end
      6: begin
        chk("R3 sub", sres, (a - b) & m);
        chk("R3 carry", scy, a >= b);
        chk("R4 sub ovf", sov, (sx(a, SW) - sx(b, SW) > 7) || (sx(a, SW) - sx(b, SW) < -8));
      end
      7:  chk("R5 slt", sres, sx(a, SW) < sx(b, SW));
      12: chk("R6 nor", sres, ~(a | b) & m);
      default: ;
    endcase
  endtask

  task automatic check_big(input logic [31:0] a, input logic [31:0] b, input logic [3:0] c);
    bit z, cy, ov;
    longint r;
    @(negedge clk);
    ba = a; bb = b; bc = c;
    #1ns;
    r = model(longint'(a), longint'(b), int'(c), BW, z, cy, ov);
    chk("R8 wide result", bres, r);
    chk("R8 wide carry", bcy, cy);
    chk("R4 wide ovf", bov, ov);
    chk("R7 wide zero", bz, z);
  endtask

  initial begin
    #800us;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    sa = '0; sb = '0; sc = 4'b0000;
    ba = '0; bb = '0; bc = 4'b0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1ns;
    // Reset-state inputs: AND of zeros
    chk("R1 init result", sres, 0);
    chk("R7 init zero", sz, 1);

    for (int c = 0; c < 16; c++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          @(negedge clk);
          sa = a[SW-1:0]; sb = b[SW-1:0]; sc = c[3:0];
          #1ns;
          check_small(a, b, c);
        end

    // Wide corners
    check_big(32'h8000_0000, 32'h0000_0001, 4'b0111); // R5 overflowing compare -> 1
    chk("R5 min<1", bres, 1);
    check_big(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111); // R5 max vs -1 -> 0
    chk("R5 max>-1", bres, 0);
    check_big(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010); // R4 positive overflow
    chk("R4 pos ovf", bov, 1);
    check_big(32'h8000_0000, 32'hFFFF_FFFF, 4'b0010); // R4 negative overflow
    chk("R4 neg ovf", bov, 1);
    check_big(32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'b0110); // R3 equal
    chk("R3 equal zero", bz, 1);
    chk("R3 equal carry", bcy, 1);
    check_big(32'h0000_0000, 32'h0000_0001, 4'b0110); // R3 borrow
    chk("R3 borrow", bres, 64'hFFFF_FFFF);
    check_big(32'hF0F0_0000, 32'h0F0F_0000, 4'b1100); // R6
    chk("R6 wide nor", bres, 64'h0000_FFFF);
    check_big(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010); // R2 wrap
    chk("R2 wrap carry", bcy, 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule